// File: doc/BRIEF.md
# Prioritized Two-Bank Interrupt Controller

This block collects up to 32 synchronous, level-sensitive interrupt requests and presents them to a processor through two independent banks: a normal bank and a fast bank, each with its own output line. The two banks share one per-source setup. That setup gives each source a polarity choice, a choice between latched and level-following behaviour, and a 4-bit priority.

Each bank has its own enable mask, a priority threshold, a masked and a raw status view, a register that names the source to service next, and a read-to-acknowledge register. The bank's output line is high while the bank has a source that passes its mask and its threshold.

Software reaches the block over a plain 32-bit register bus with word addresses. Writes take effect on the clock edge where the write strobe is sampled. Read data is registered. A handler typically loops: it reads the current-source register, services that source, and reads the acknowledge register. It stops when the masked status reads zero.

Top module: `dualBankIntc`

## Requirements
- R1: After reset, both enable masks are 0, both thresholds are 0xF, polarity select is all ones, sticky select is 0, every priority is 0, both output lines are low and read data is 0.
- R2: In a bank, writing to offset 0x08 sets every mask bit that is 1 in the write data. Writing to offset 0x0C clears every mask bit that is 1 in the write data. Zero bits leave the mask unchanged. Reading offset 0x08 returns the mask.
- R3: Offset 0x04 of a bank reads the raw pending vector, one bit per source with bit i for source i. Offset 0x00 reads the raw vector ANDed with that bank's mask.
- R4: The polarity register at 0x200 takes source i without inversion when bit i is 1, and inverted when bit i is 0.
- R5: The sticky register at 0x204 makes a source with bit i set hold its pending bit after the input drops, until it is acknowledged. With bit i clear, the pending bit follows the level.
- R6: Offset 0x20 of a bank reads the index of the pending, enabled source with the numerically lowest priority among those within the threshold. On equal priority the lowest index wins. The register reads 32 when no source qualifies.
- R7: The threshold at bank offset 0x2C (4 bits) excludes sources whose priority value exceeds it from the current-source register and from the output line. Those sources still show in both status registers.
- R8: Reading bank offset 0x28 returns the same value as offset 0x20. In the same cycle it clears the sticky latch of the source that the bank reports. A level-following source stays pending while its input is active.
- R9: Each bank's output line is high one cycle after that bank has a qualifying source, and low one cycle after it has none.
- R10: The normal bank sits at 0x000 and the fast bank at 0x100 with the same layout. Each bank's mask and threshold act only on its own status, current source and output line.
- R11: Read data appears on the cycle after a read strobe and holds until the next read. Unmapped addresses, and the write-only offset 0x0C, read 0.
- R12: Source i's priority is a word register at 0x300 + 4*i that holds its low 4 bits and reads them back. Priority 0 is the most urgent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | 32 | Synchronous interrupt request lines |
| busAddr | input | 12 | Register byte address, word aligned |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRd | input | 1 | Read strobe |
| busRdata | output | 32 | Registered read data |
| irqOut | output | 1 | Normal bank request line |
| fiqOut | output | 1 | Fast bank request line |

## Verification
Random request vectors are combined with random polarity, masks, thresholds and priorities, and with the sticky feature off. Each bank's status, current source and line are then compared against a bench model, which separates masking faults from arbitration faults. Directed sequences cover the cases that random vectors rarely reach. A single pulse on a latched source is followed by an acknowledge, which tells a latch that is cleared apart from one that is lost or one that is kept. Equal priorities and a threshold below every pending priority isolate the tie-break rule and the threshold compare. A source enabled in only one bank shows whether the two banks stay separate.

// File: rtl/icPkg.sv
package icPkg;
  parameter int unsigned IcNumBank = 2;
  parameter int unsigned IcWordIdxW = 6;

  typedef enum logic [3:0] {
    RD_NONE,
    RD_STATUS,
    RD_RAW,
    RD_ENABLE,
    RD_CURRENT,
    RD_THRESH,
    RD_POL,
    RD_STICKY,
    RD_PRIO,
    RD_ZERO
  } icRdSel_e;

  typedef struct packed {
    logic [IcNumBank-1:0] setEn;
    logic [IcNumBank-1:0] clrEn;
    logic [IcNumBank-1:0] setThr;
    logic [IcNumBank-1:0] ack;
    logic                 setPol;
    logic                 setSticky;
    logic                 setPrio;
    logic [IcWordIdxW-1:0] prioIdx;
    icRdSel_e             rdSel;
    logic                 rdBank;
  } icStrobe_t;
endpackage

// File: rtl/icArb.sv
module icArb #(
  parameter int unsigned NumSrc = 32,
  parameter int unsigned PrioW  = 4,
  localparam int unsigned IdxW  = $clog2(NumSrc + 1)
) (
  input  logic [NumSrc-1:0]            cand,
  input  logic [NumSrc-1:0][PrioW-1:0] prio,
  input  logic [PrioW-1:0]             thresh,
  output logic [IdxW-1:0]              curIdx,
  output logic                         hit
);
  logic [PrioW-1:0] bestPrio;

  // Linear scan: strict compare keeps the lowest index on equal priority.
  always_comb begin
    hit      = 1'b0;
    curIdx   = IdxW'(NumSrc);
    bestPrio = '1;
    for (int i = 0; i < NumSrc; i++) begin
      if (cand[i] && (prio[i] <= thresh) && (!hit || (prio[i] < bestPrio))) begin
        hit      = 1'b1;
        bestPrio = prio[i];
        curIdx   = IdxW'(i);
      end
    end
  end
endmodule

// File: rtl/icCtrl.sv
module icCtrl
  import icPkg::*;
#(
  parameter int unsigned NumSrc = 32,
  parameter int unsigned AddrW  = 12
) (
  input  logic [AddrW-1:0] busAddr,
  input  logic             busWr,
  input  logic             busRd,
  output icStrobe_t        strb
);
  localparam int unsigned HiW  = AddrW - 8;
  localparam int unsigned IdxW1 = IcWordIdxW + 1;
  localparam logic [HiW-1:0] RegionBank0 = HiW'(0);
  localparam logic [HiW-1:0] RegionBank1 = HiW'(1);
  localparam logic [HiW-1:0] RegionSetup = HiW'(2);
  localparam logic [HiW-1:0] RegionPrio  = HiW'(3);
  localparam logic [IdxW1-1:0] NumSrcW  = IdxW1'(NumSrc);

  localparam logic [7:0] OffStatus  = 8'h00;
  localparam logic [7:0] OffRaw     = 8'h04;
  localparam logic [7:0] OffEnable  = 8'h08;
  localparam logic [7:0] OffDisable = 8'h0C;
  localparam logic [7:0] OffCurrent = 8'h20;
  localparam logic [7:0] OffAck     = 8'h28;
  localparam logic [7:0] OffThresh  = 8'h2C;
  localparam logic [7:0] OffPol     = 8'h00;
  localparam logic [7:0] OffSticky  = 8'h04;

  logic [HiW-1:0] region;
  logic [7:0]     off;
  logic           bankSel;
  logic           inBank;
  logic           prioOk;

  assign region  = busAddr[AddrW-1:8];
  assign off     = busAddr[7:0];
  assign bankSel = busAddr[8];
  assign inBank  = (region == RegionBank0) || (region == RegionBank1);
  assign prioOk  = (region == RegionPrio) && (busAddr[1:0] == 2'b00) &&
                   ({1'b0, busAddr[IcWordIdxW+1:2]} < NumSrcW);

  always_comb begin
    strb         = '0;
    strb.rdSel   = RD_NONE;
    strb.rdBank  = bankSel;
    strb.prioIdx = busAddr[IcWordIdxW+1:2];
    if (busWr) begin
      if (inBank) begin
        case (off)
          OffEnable:  strb.setEn[bankSel]  = 1'b1;
          OffDisable: strb.clrEn[bankSel]  = 1'b1;
          OffThresh:  strb.setThr[bankSel] = 1'b1;
          default: ;
        endcase
      end else if (region == RegionSetup) begin
        if (off == OffPol)    strb.setPol    = 1'b1;
        if (off == OffSticky) strb.setSticky = 1'b1;
      end else if (prioOk) begin
        strb.setPrio = 1'b1;
      end
    end
    if (busRd) begin
      strb.rdSel = RD_ZERO;
      if (inBank) begin
        case (off)
          OffStatus:  strb.rdSel = RD_STATUS;
          OffRaw:     strb.rdSel = RD_RAW;
          OffEnable:  strb.rdSel = RD_ENABLE;
          OffCurrent: strb.rdSel = RD_CURRENT;
          OffThresh:  strb.rdSel = RD_THRESH;
          OffAck: begin
            strb.rdSel         = RD_CURRENT;
            strb.ack[bankSel]  = 1'b1;
          end
          default: strb.rdSel = RD_ZERO;
        endcase
      end else if (region == RegionSetup) begin
        if (off == OffPol)    strb.rdSel = RD_POL;
        if (off == OffSticky) strb.rdSel = RD_STICKY;
      end else if (prioOk) begin
        strb.rdSel = RD_PRIO;
      end
    end
  end
endmodule

// File: rtl/icDatapath.sv
module icDatapath
  import icPkg::*;
#(
  parameter int unsigned NumSrc = 32,
  parameter int unsigned PrioW  = 4,
  parameter int unsigned DataW  = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NumSrc-1:0]    srcIn,
  input  icStrobe_t            strb,
  input  logic [DataW-1:0]     wdata,
  output logic [DataW-1:0]     rdata,
  output logic [IcNumBank-1:0] bankHit,
  output logic [IcNumBank-1:0] bankIrq
);
  localparam int unsigned IdxW    = $clog2(NumSrc + 1);
  localparam int unsigned SrcIdxW = $clog2(NumSrc);

  logic [NumSrc-1:0]                polSel;
  logic [NumSrc-1:0]                stickySel;
  logic [NumSrc-1:0]                latchReg;
  logic [NumSrc-1:0][PrioW-1:0]     prioReg;
  logic [IcNumBank-1:0][NumSrc-1:0] enMask;
  logic [IcNumBank-1:0][PrioW-1:0]  thresh;
  logic [IcNumBank-1:0][IdxW-1:0]   curIdx;

  logic [NumSrc-1:0] level;
  logic [NumSrc-1:0] rawPend;
  logic [NumSrc-1:0] ackClr;
  logic [SrcIdxW-1:0] prioSel;
  logic [DataW-1:0]  rdMux;

  assign level   = ~(srcIn ^ polSel);
  assign rawPend = (stickySel & latchReg) | (~stickySel & level);
  assign prioSel = strb.prioIdx[SrcIdxW-1:0];

  for (genvar b = 0; b < IcNumBank; b++) begin : g_bank
    icArb #(.NumSrc(NumSrc), .PrioW(PrioW)) u_arb (
      .cand  (rawPend & enMask[b]),
      .prio  (prioReg),
      .thresh(thresh[b]),
      .curIdx(curIdx[b]),
      .hit   (bankHit[b])
    );
  end

  always_comb begin
    ackClr = '0;
    for (int b = 0; b < IcNumBank; b++) begin
      if (strb.ack[b] && bankHit[b]) ackClr = ackClr | (NumSrc'(1) << curIdx[b]);
    end
  end

  // Per-source setup shared by both banks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polSel    <= '1;
      stickySel <= '0;
      prioReg   <= '0;
    end else begin
      if (strb.setPol)    polSel    <= wdata[NumSrc-1:0];
      if (strb.setSticky) stickySel <= wdata[NumSrc-1:0];
      if (strb.setPrio)   prioReg[prioSel] <= wdata[PrioW-1:0];
    end
  end

  // Per-bank masks and thresholds
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask <= '0;
      thresh <= '1;
    end else begin
      for (int b = 0; b < IcNumBank; b++) begin
        if (strb.setEn[b])      enMask[b] <= enMask[b] | wdata[NumSrc-1:0];
        else if (strb.clrEn[b]) enMask[b] <= enMask[b] & ~wdata[NumSrc-1:0];
        if (strb.setThr[b])     thresh[b] <= wdata[PrioW-1:0];
      end
    end
  end

  // Sticky latches: acknowledge wins over a set in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latchReg <= '0;
    else       latchReg <= (latchReg | level) & stickySel & ~ackClr;
  end

  always_comb begin
    case (strb.rdSel)
      RD_STATUS:  rdMux = DataW'(rawPend & enMask[strb.rdBank]);
      RD_RAW:     rdMux = DataW'(rawPend);
      RD_ENABLE:  rdMux = DataW'(enMask[strb.rdBank]);
      RD_CURRENT: rdMux = DataW'(curIdx[strb.rdBank]);
      RD_THRESH:  rdMux = DataW'(thresh[strb.rdBank]);
      RD_POL:     rdMux = DataW'(polSel);
      RD_STICKY:  rdMux = DataW'(stickySel);
      RD_PRIO:    rdMux = DataW'(prioReg[prioSel]);
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata   <= '0;
      bankIrq <= '0;
    end else begin
      bankIrq <= bankHit;
      if (strb.rdSel != RD_NONE) rdata <= rdMux;
    end
  end
endmodule

// File: rtl/dualBankIntc.sv
module dualBankIntc
  import icPkg::*;
#(
  parameter int unsigned NumSrc = 32,
  parameter int unsigned PrioW  = 4,
  parameter int unsigned AddrW  = 12,
  parameter int unsigned DataW  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumSrc-1:0] srcIn,
  input  logic [AddrW-1:0]  busAddr,
  input  logic              busWr,
  input  logic [DataW-1:0]  busWdata,
  input  logic              busRd,
  output logic [DataW-1:0]  busRdata,
  output logic              irqOut,
  output logic              fiqOut
);
  icStrobe_t            strb;
  logic [IcNumBank-1:0] bankHit;
  logic [IcNumBank-1:0] bankIrq;

  icCtrl #(.NumSrc(NumSrc), .AddrW(AddrW)) u_ctrl (
    .busAddr(busAddr),
    .busWr  (busWr),
    .busRd  (busRd),
    .strb   (strb)
  );

  icDatapath #(.NumSrc(NumSrc), .PrioW(PrioW), .DataW(DataW)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .srcIn  (srcIn),
    .strb   (strb),
    .wdata  (busWdata),
    .rdata  (busRdata),
    .bankHit(bankHit),
    .bankIrq(bankIrq)
  );

  assign irqOut = bankIrq[0];
  assign fiqOut = bankIrq[1];
endmodule

// File: rtl/icChk.sv
module icChk #(
  parameter int unsigned NumSrc = 32,
  parameter int unsigned AddrW  = 12,
  parameter int unsigned DataW  = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [AddrW-1:0] busAddr,
  input logic             busWr,
  input logic [DataW-1:0] busWdata,
  input logic             busRd,
  input logic [DataW-1:0] busRdata,
  input logic             irqOut,
  input logic             fiqOut,
  input logic [1:0]       bankHit
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> (!irqOut && !fiqOut));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdata));

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    bankHit[0] |=> irqOut);

  // R9
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bankHit[0] |=> !irqOut);

  // R10
  fiq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    bankHit[1] |=> fiqOut);

  // R6
  idle_current_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == AddrW'(12'h020) && !bankHit[0]) |=> busRdata == DataW'(NumSrc));

  // R2
  disable_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == AddrW'(12'h00C) && (&busWdata)) |=> !bankHit[0]);
endmodule

bind dualBankIntc icChk #(.NumSrc(NumSrc), .AddrW(AddrW), .DataW(DataW)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busWr   (busWr),
  .busWdata(busWdata),
  .busRd   (busRd),
  .busRdata(busRdata),
  .irqOut  (irqOut),
  .fiqOut  (fiqOut),
  .bankHit (bankHit)
);

// File: tb/dualBankIntc_tb.sv
`timescale 1ns/1ps
module dualBankIntc_tb;
  localparam int NumSrc = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic [11:0] busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRd = 1'b0;
  logic [31:0] busRdata;
  logic        irqOut, fiqOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  logic [31:0] mPol;
  logic [31:0] mEn [2];
  logic [3:0]  mThr [2];
  logic [3:0]  mPrio [NumSrc];

  always #4 clk = ~clk;

  dualBankIntc u_dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRd(busRd), .busRdata(busRdata),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  function automatic logic [31:0] expRaw();
    return ~(srcIn ^ mPol);
  endfunction

  function automatic logic [31:0] expCur(input int b);
    logic [31:0] p;
    int best;
    int bp;
    p = expRaw() & mEn[b];
    best = NumSrc;
    bp = 16;
    for (int i = 0; i < NumSrc; i++)
      if (p[i] && mPrio[i] <= mThr[b] && int'(mPrio[i]) < bp) begin
        best = i; bp = int'(mPrio[i]);
      end
    return 32'(best);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] seedDummy;
    seedDummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R1 rdata", busRdata, 32'h0);
    check("R1 irq", {31'b0, irqOut}, 32'h0);
    check("R1 fiq", {31'b0, fiqOut}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    busRead(12'h008, d); check("R1 enable bank0", d, 32'h0);
    busRead(12'h108, d); check("R1 enable bank1", d, 32'h0);
    busRead(12'h02C, d); check("R1 thresh bank0", d, 32'hF);
    busRead(12'h12C, d); check("R1 thresh bank1", d, 32'hF);
    busRead(12'h200, d); check("R1 polarity", d, 32'hFFFF_FFFF);
    busRead(12'h204, d); check("R1 sticky", d, 32'h0);
    busRead(12'h314, d); check("R1 prio5", d, 32'h0);

    // R2 set/clear semantics
    busWrite(12'h008, 32'h0000_00F0);
    busWrite(12'h008, 32'h0000_0003);
    busRead(12'h008, d); check("R2 set", d, 32'h0000_00F3);
    busWrite(12'h00C, 32'h0000_0021);
    busRead(12'h008, d); check("R2 clear", d, 32'h0000_00D2);
    busRead(12'h00C, d); check("R11 write-only reads 0", d, 32'h0);

    // R3 / R4 status and polarity
    srcIn = 32'h0000_0012;
    busRead(12'h004, d); check("R3 raw", d, 32'h0000_0012);
    busRead(12'h000, d); check("R3 masked", d, 32'h0000_0012);
    busWrite(12'h200, 32'hFFFF_FFF7);
    busRead(12'h004, d); check("R4 inverted bit3", d, 32'h0000_001A);
    busRead(12'h000, d); check("R3 masked after invert", d, 32'h0000_0012);
    busWrite(12'h200, 32'hFFFF_FFFF);
    srcIn = '0;
    busWrite(12'h00C, 32'hFFFF_FFFF);

    // R5 / R8 sticky latch and acknowledge
    busWrite(12'h204, 32'h0000_0020);
    busWrite(12'h008, 32'h0000_00A0);
    srcIn = 32'h0000_0020;
    @(negedge clk);
    srcIn = '0;
    busRead(12'h004, d); check("R5 latched", d, 32'h0000_0020);
    check("R9 irq high", {31'b0, irqOut}, 32'h1);
    busRead(12'h020, d); check("R6 current sticky", d, 32'd5);
    srcIn = 32'h0000_0080;
    busRead(12'h028, d); check("R8 ack returns current", d, 32'd5);
    busRead(12'h004, d); check("R8 latch cleared", d, 32'h0000_0080);
    busRead(12'h020, d); check("R6 next source", d, 32'd7);
    busRead(12'h028, d); check("R8 ack level", d, 32'd7);
    busRead(12'h004, d); check("R8 level stays", d, 32'h0000_0080);
    srcIn = '0;
    busRead(12'h004, d); check("R5 follows level", d, 32'h0);
    check("R9 irq low", {31'b0, irqOut}, 32'h0);
    busWrite(12'h204, 32'h0);
    busWrite(12'h00C, 32'hFFFF_FFFF);

    // R6 / R7 / R12 priority, tie, threshold
    busWrite(12'h308, 32'h3);
    busWrite(12'h324, 32'h3);
    busWrite(12'h350, 32'h1);
    busRead(12'h324, d); check("R12 prio readback", d, 32'h3);
    busWrite(12'h008, 32'h0010_0204);
    srcIn = 32'h0010_0204;
    busWrite(12'h02C, 32'h0);
    busRead(12'h020, d); check("R7 none within threshold", d, 32'd32);
    busRead(12'h000, d); check("R7 status kept", d, 32'h0010_0204);
    check("R7 line low", {31'b0, irqOut}, 32'h0);
    busWrite(12'h02C, 32'h1);
    busRead(12'h020, d); check("R6 lowest value", d, 32'd20);
    check("R9 line high", {31'b0, irqOut}, 32'h1);
    busWrite(12'h02C, 32'hF);
    busWrite(12'h00C, 32'h0010_0000);
    busRead(12'h020, d); check("R6 tie lowest index", d, 32'd2);

    // R10 bank independence
    busWrite(12'h108, 32'h0000_0200);
    busRead(12'h120, d); check("R10 fast current", d, 32'd9);
    busRead(12'h100, d); check("R10 fast status", d, 32'h0000_0200);
    busRead(12'h020, d); check("R10 normal unaffected", d, 32'd2);
    check("R10 fast line", {31'b0, fiqOut}, 32'h1);
    busRead(12'h128, d); check("R10 fast ack", d, 32'd9);
    busWrite(12'h00C, 32'hFFFF_FFFF);
    busRead(12'h020, d); check("R10 normal idle", d, 32'd32);
    check("R10 normal line low", {31'b0, irqOut}, 32'h0);
    busRead(12'h120, d); check("R10 fast still active", d, 32'd9);
    repeat (3) @(negedge clk);
    check("R11 hold", busRdata, 32'd9);
    busRead(12'h3F0, d); check("R11 unmapped", d, 32'h0);
    busRead(12'h240, d); check("R11 unmapped setup", d, 32'h0);

    // Random phase: level sources only
    srcIn = '0;
    busWrite(12'h10C, 32'hFFFF_FFFF);
    mPol = 32'hFFFF_FFFF;
    for (int b = 0; b < 2; b++) begin mEn[b] = '0; mThr[b] = 4'hF; end
    for (int i = 0; i < NumSrc; i++) begin
      mPrio[i] = 4'($urandom);
      busWrite(12'(12'h300 + 4 * i), 32'(mPrio[i]));
    end
    for (int it = 0; it < 40; it++) begin
      srcIn = $urandom;
      mPol = $urandom | $urandom;
      busWrite(12'h200, mPol);
      for (int b = 0; b < 2; b++) begin
        mEn[b] = $urandom & $urandom;
        mThr[b] = 4'($urandom);
        busWrite(12'(b * 256 + 12), 32'hFFFF_FFFF);
        busWrite(12'(b * 256 + 8), mEn[b]);
        busWrite(12'(b * 256 + 44), 32'(mThr[b]));
      end
      for (int k = 0; k < 6; k++) begin
        int s;
        s = int'($urandom % NumSrc);
        mPrio[s] = 4'($urandom);
        busWrite(12'(12'h300 + 4 * s), 32'(mPrio[s]));
      end
      for (int b = 0; b < 2; b++) begin
        busRead(12'(b * 256 + 4), d); check("R3 random raw", d, expRaw());
        busRead(12'(b * 256), d); check("R3 random masked", d, expRaw() & mEn[b]);
        busRead(12'(b * 256 + 32), d); check("R6 random current", d, expCur(b));
      end
      check("R9 random irq", {31'b0, irqOut}, {31'b0, expCur(0) != 32});
      check("R10 random fiq", {31'b0, fiqOut}, {31'b0, expCur(1) != 32});
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule